// File: doc/BRIEF.md
# Peripheral Clock Ratio Divider

This block makes a peripheral clock from the processor clock. The ratio is one of three values: full rate, one half or one quarter. Software picks the ratio through a two-bit code held in an 8-bit read/write control register. The block has two outputs. The first is the divided clock, `pclk`. The second is `pclk_en`, a strobe one processor cycle wide that marks the first cycle of every peripheral clock period. Logic that runs on the processor clock can use `pclk_en` as a clock enable.

After reset the block runs at one quarter rate. The bus that carries the control register is paced by this clock, so it must work before software has written anything. A new code is taken up only when the current period has ended, at a point where the divided clock is low. A period is therefore never cut short. The divider keeps running while the system is in idle mode.

Top module: `pclk_ratio_div`

## Requirements
- R1: After reset is released, with no write made, the register reads 0x00. `pclk` is high for 2 processor cycles and low for 2 cycles, and the first period begins on the first clock edge after reset.
- R2: Code 2'b01 selects divide-by-one. `pclk` follows the processor clock, and `pclk_en` is high in every cycle.
- R3: Code 2'b10 selects divide-by-two. `pclk` is high for 1 cycle and low for 1 cycle.
- R4: Codes 2'b00 and 2'b11 both select divide-by-four.
- R5: A write with `wr_en` high stores `wdata[1:0]`, and `rdata` shows it after that clock edge. The write ignores `wdata[7:2]`, and `rdata[7:2]` always reads zero.
- R6: A new code takes effect only at the end of the current period. The running period finishes with its old length, and the next period starts with `pclk` rising.
- R7: `pclk_en` is high for exactly one processor cycle per peripheral period. That cycle is the first cycle of the period.
- R8: `idle_mode` has no effect on `pclk`, `pclk_en` or `rdata`.
- R9: While reset is asserted, `pclk` and `pclk_en` are low and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data; bits [1:0] hold the ratio code |
| rdata | output | 8 | Read-back of the control register |
| idle_mode | input | 1 | System idle indication; the divider keeps running |
| pclk | output | 1 | Divided peripheral clock |
| pclk_en | output | 1 | One-cycle strobe at the start of each peripheral period |

## Verification
The bench runs every code at a steady rate. This separates the three period lengths and shows that code 2'b11 gives the same divide-by-four as code 2'b00. Writes with the upper data bits set show whether those bits leak into the stored value. Some codes are written part way through a period. These writes show whether the old period runs to its full length before the switch. Holding `idle_mode` high while the divider runs shows whether idle has any influence on the outputs.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  localparam int CODE_W = 2;
  localparam int CNT_W  = 2;

  typedef enum logic [1:0] {
    RATIO_DIV4 = 2'd0,
    RATIO_DIV1 = 2'd1,
    RATIO_DIV2 = 2'd2
  } ratio_e;

  // Decode the software code; the spare code aliases the slowest ratio.
  function automatic ratio_e code_to_ratio(input logic [CODE_W-1:0] code);
    case (code)
      2'b01:   return RATIO_DIV1;
      2'b10:   return RATIO_DIV2;
      default: return RATIO_DIV4;
    endcase
  endfunction

  // Last count value of a period for a given ratio.
  function automatic logic [CNT_W-1:0] last_count(input ratio_e r);
    case (r)
      RATIO_DIV1: return 2'd0;
      RATIO_DIV2: return 2'd1;
      default:    return 2'd3;
    endcase
  endfunction

  // Whether the registered clock is high at a given count.
  function automatic logic high_phase(input ratio_e r, input logic [CNT_W-1:0] cnt);
    case (r)
      RATIO_DIV1: return 1'b1;
      RATIO_DIV2: return (cnt == 2'd0);
      default:    return (cnt < 2'd2);
    endcase
  endfunction

endpackage

// File: rtl/pclk_ctrl_reg.sv
module pclk_ctrl_reg
  import pclk_div_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic [CODE_W-1:0]   code
);

  localparam logic [REG_W-1:0] RW_MASK = {{(REG_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= '0;
    else if (wr_en) reg_q <= wdata & RW_MASK;
  end

  assign rdata = reg_q;
  assign code  = reg_q[CODE_W-1:0];

endmodule

// File: rtl/pclk_ratio_sel.sv
module pclk_ratio_sel
  import pclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              period_end,
  output ratio_e            act_ratio,
  output ratio_e            next_ratio
);

  ratio_e act_q;

  // The ratio that will be active after the coming edge.
  assign next_ratio = period_end ? code_to_ratio(code) : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= RATIO_DIV4;
    else        act_q <= next_ratio;
  end

  assign act_ratio = act_q;

endmodule

// File: rtl/pclk_div_core.sv
module pclk_div_core
  import pclk_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  ratio_e act_ratio,
  input  ratio_e next_ratio,
  output logic   period_end,
  output logic   pclk,
  output logic   pclk_en
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pclk_q;

  assign period_end = adv && (cnt_q == last_count(act_ratio));

  always_comb begin
    if (!adv)           cnt_d = cnt_q;
    else if (period_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  // The reset value puts the counter at a period end, so the first edge opens a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 2'd3;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= high_phase(next_ratio, cnt_d);
    end
  end

  assign pclk_en = rst_n && (cnt_q == '0);
  // Full rate passes the processor clock through. The switch happens at a rising edge, so every pulse is whole.
  assign pclk    = (act_ratio == RATIO_DIV1) ? clk : pclk_q;

endmodule

// File: rtl/pclk_ratio_div.sv
module pclk_ratio_div
  import pclk_div_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter bit IDLE_RUN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             idle_mode,
  output logic             pclk,
  output logic             pclk_en
);

  logic [CODE_W-1:0] sel_code;
  ratio_e            act_ratio;
  ratio_e            next_ratio;
  logic              period_end;
  logic              adv;

  // The divider advances in idle unless the variant parameter says otherwise.
  assign adv = IDLE_RUN ? 1'b1 : ~idle_mode;

  pclk_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .code  (sel_code)
  );

  pclk_ratio_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (sel_code),
    .period_end (period_end),
    .act_ratio  (act_ratio),
    .next_ratio (next_ratio)
  );

  pclk_div_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .act_ratio  (act_ratio),
    .next_ratio (next_ratio),
    .period_end (period_end),
    .pclk       (pclk),
    .pclk_en    (pclk_en)
  );

endmodule

// File: rtl/pclk_ratio_div_chk.sv
module pclk_ratio_div_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic             pclk_en,
  input logic             period_end,
  input logic [1:0]       act_ratio,
  input logic [1:0]       sel_code
);

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:2] == '0);

  // R5
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata[1:0] == $past(wdata[1:0]));

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_ratio));

  // R4
  div4_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && (sel_code == 2'b00 || sel_code == 2'b11)) |=> act_ratio == 2'd0);

  // R7
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> pclk_en);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_en && act_ratio != 2'd1 && !period_end) |=> !pclk_en);

endmodule

bind pclk_ratio_div pclk_ratio_div_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .pclk_en    (pclk_en),
  .period_end (period_end),
  .act_ratio  (act_ratio),
  .sel_code   (sel_code)
);

// File: tb/pclk_ratio_div_tb.sv
`timescale 1ns/1ps
module pclk_ratio_div_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       idle_mode = 1'b0;
  logic       pclk;
  logic       pclk_en;

  int errors = 0;
  int checks = 0;
  string tag = "R9";

  // Reference state
  int m_cnt = 3;
  int m_div = 4;
  int m_code = 0;
  int en_hist[$];

  always #2.5 clk = ~clk;

  pclk_ratio_div u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .idle_mode(idle_mode), .pclk(pclk), .pclk_en(pclk_en)
  );

  function automatic int ratio_of(input int code);
    if (code == 1) return 1;
    if (code == 2) return 2;
    return 4;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One processor cycle. Inputs were set away from the edge; advance the model and compare shortly after the edge.
  task automatic step();
    @(posedge clk);
    #1;
    if (m_cnt == m_div - 1) begin
      m_cnt = 0;
      m_div = ratio_of(m_code);
    end else begin
      m_cnt = m_cnt + 1;
    end
    if (wr_en) m_code = wdata & 8'h03;
    en_hist.push_back(m_cnt == 0);
    check(tag, "pclk", pclk, (m_div == 1) ? 1 : (m_cnt < m_div / 2));
    check(tag, "pclk_en", pclk_en, m_cnt == 0);
    check(tag, "rdata", rdata, m_code);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = v;
    step();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int c);
    while (m_cnt != c) step();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9", "pclk in reset", pclk, 0);
    check("R9", "pclk_en in reset", pclk_en, 0);
    check("R9", "rdata in reset", rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: quarter rate from reset, first period on first edge
    tag = "R1";
    run(12);

    // R7: strobe count over a whole number of quarter periods
    en_hist.delete();
    tag = "R7";
    run(16);
    begin
      int n = 0;
      foreach (en_hist[i]) n += en_hist[i];
      check("R7", "strobes in 16 cycles at div4", n, 4);
    end

    // R2: full rate
    tag = "R6";
    wait_cnt(1);
    write(8'h01);
    tag = "R2";
    run(10);

    // R3 and R5: divide by two, upper bits set in the write
    tag = "R5";
    write(8'hFE);
    check("R5", "upper bits dropped", rdata, 8'h02);
    tag = "R3";
    run(12);

    // R4: spare code aliases quarter; switch requested mid-period (R6)
    tag = "R6";
    wait_cnt(1);
    write(8'h03);
    tag = "R4";
    run(16);
    check("R4", "rdata after code 11", rdata, 3);

    // R6: switch to half rate in the middle of a quarter period
    tag = "R6";
    wait_cnt(1);
    write(8'h02);
    run(8);

    // R8: idle has no influence, at each ratio
    idle_mode = 1'b1;
    tag = "R8";
    run(10);
    write(8'h00);
    run(12);
    write(8'h81);
    run(8);
    idle_mode = 1'b0;

    // R4: code 00 back to quarter
    tag = "R4";
    write(8'h00);
    run(12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule